// File: doc/BRIEF.md
# Long-Press Reset Pulse Generator

This block watches an active-low push-button and sorts each press into short or long. A short press leaves the output untouched. A press held for the full hold time produces one reset pulse of fixed width. The output is an open-drain line: the block either pulls it low or lets it float high. The line then stays released until the button has been let go, so holding the button down yields exactly one pulse.

The hold and pulse times are given in milliseconds and converted to clock cycles from a clock-frequency parameter. With the defaults, the hold time is 7.5 s and the pulse is 400 ms. A delay-select input switches the block into a zero-delay test mode, in which the pulse starts as soon as the press is seen. The pulse width is the same in both modes. The block reads the delay-select input only while the button is released. Both inputs pass through two-flop synchronizers before any logic uses them.

Top module: `lp_reset_gen`

## Requirements
- R1: `btn_ni` and `test_sel_i` each pass through two synchronizer flops. In test mode, if `btn_ni` falls just after clock edge t0, `rst_pull_o` is first seen high after edge t0+3.
- R2: If `btn_ni` is low for fewer than HOLD cycles (HOLD = CLK_HZ/1000*HOLD_MS), no pulse is produced.
- R3: If `btn_ni` is low for HOLD cycles or more in normal mode, `rst_pull_o` rises after edge t0+HOLD+2. The comparison is inclusive.
- R4: A pulse lasts exactly PULSE = CLK_HZ/1000*PULSE_MS cycles, whatever `btn_ni` does during it.
- R5: After a pulse, the block re-arms only once `btn_ni` has been seen high. A button that stays held produces no second pulse, and a later press works normally.
- R6: When the synchronized `test_sel_i` is 1 while the button is released, the next press starts a pulse without any hold delay. The pulse width is again PULSE.
- R7: The mode is latched only while the synchronized button is high. A `test_sel_i` change made and undone while the button is held has no effect on the mode.
- R8: The output is open-drain. `rst_pull_o` = 1 means the line is pulled low, and `rst_no` is then 0. Otherwise `rst_no` is 1, the released level.
- R9: `rst_ni` low immediately releases the output, clears both counters and selects normal mode. This holds even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 1 | Push-button, active low, asynchronous |
| test_sel_i | input | 1 | 1 selects zero-delay test mode, asynchronous |
| rst_pull_o | output | 1 | Pull-low enable of the open-drain reset line |
| rst_no | output | 1 | Resulting active-low reset level |

## Verification
Press lengths are swept around the hold threshold: HOLD-2, HOLD-1, HOLD, HOLD+1, then releases during the pulse and holds well past it. This separates an off-by-one in the inclusive comparison from one in the synchronizer latency, and shows that the pulse width does not depend on the release time. Holding the button far beyond the pulse, followed by a fresh press, tells a missing re-arm apart from a retrigger. Flipping the delay-select input while the button is held, and again while it is released, shows whether the mode is latched at the right moment. A reset in the middle of a pulse checks the asynchronous release.

// File: rtl/lp_reset_pkg.sv
package lp_reset_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PULSE,
    ST_WAIT_REL
  } lp_state_e;

  function automatic int unsigned ms_to_cyc(longint unsigned clk_hz, longint unsigned ms);
    longint unsigned c;
    c = (clk_hz / 64'd1000) * ms;
    return int'(c);
  endfunction
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/lp_tick_cnt.sv
module lp_tick_cnt #(
  parameter int unsigned TARGET = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(TARGET + 1);
  localparam logic [W-1:0] TGT = W'(TARGET);

  logic [W-1:0] cnt_q;

  // run_i low clears; counting only while the owning state persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + W'(1);
    else            cnt_q <= '0;
  end

  assign hit_o = (cnt_q == TGT);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TGT);
endmodule

// File: rtl/lp_reset_gen.sv
module lp_reset_gen
  import lp_reset_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned HOLD_MS  = 7500,
  parameter int unsigned PULSE_MS = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic test_sel_i,
  output logic rst_pull_o,
  output logic rst_no
);
  localparam int unsigned HOLD_CYC  = ms_to_cyc(CLK_HZ, HOLD_MS);
  localparam int unsigned PULSE_CYC = ms_to_cyc(CLK_HZ, PULSE_MS);

  initial begin
    p_cfg_r3: assert (HOLD_CYC >= 2 && PULSE_CYC >= 1);
  end

  logic btn_s, sel_s;
  lp_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({btn_ni, test_sel_i}),
    .q_o   ({btn_s, sel_s})
  );

  lp_state_e state_q, state_d;
  logic      test_q;
  logic      hold_hit, pulse_hit;

  lp_tick_cnt #(.TARGET(HOLD_CYC - 1)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_d == ST_HOLD),
    .hit_o (hold_hit)
  );

  lp_tick_cnt #(.TARGET(PULSE_CYC)) u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_d == ST_PULSE),
    .hit_o (pulse_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (!btn_s) state_d = test_q ? ST_PULSE : ST_HOLD;
      ST_HOLD: begin
        if (btn_s)         state_d = ST_IDLE;
        else if (hold_hit) state_d = ST_PULSE;
      end
      ST_PULSE:    if (pulse_hit) state_d = btn_s ? ST_IDLE : ST_WAIT_REL;
      ST_WAIT_REL: if (btn_s) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      test_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // mode latched only while released
      if (state_q == ST_IDLE && btn_s) test_q <= sel_s;
    end
  end

  assign rst_pull_o = (state_q == ST_PULSE);
  assign rst_no     = ~rst_pull_o;

  p_rise_needs_press_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pull_o) |-> $past(!btn_s));
  p_short_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && btn_s) |=> !rst_pull_o);
  p_no_retrigger_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_REL) |=> !$rose(rst_pull_o));
  p_mode_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_q) |-> ($past(btn_s) && $past(state_q == ST_IDLE)));
endmodule

// File: tb/lp_reset_gen_tb.sv
module lp_reset_gen_tb_top;
  localparam int H = 20;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic sel = 1'b0;
  logic pull, rst_lvl;

  int total = 0, bad = 0;
  int cyc = 0, pulses = 0, rise_cyc = 0, width = 0, od_bad = 0;
  logic prev = 1'b0;

  lp_reset_gen #(.CLK_HZ(1000), .HOLD_MS(H), .PULSE_MS(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .test_sel_i(sel),
    .rst_pull_o(pull), .rst_no(rst_lvl)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pull && !prev) begin rise_cyc = cyc; pulses++; end
    if (!pull && prev) width = cyc - rise_cyc;
    if (rst_lvl !== !pull) od_bad++;
    prev = pull;
  end

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // exp_lat < 0: no pulse expected
  task automatic run_press(int len, int exp_lat, string req);
    int p0, t0;
    p0 = pulses;
    @(negedge clk); btn_n = 1'b0; t0 = cyc;
    repeat (len) @(negedge clk);
    btn_n = 1'b1;
    repeat (H + P + 8) @(negedge clk);
    if (exp_lat < 0) chk(req, pulses == p0, pulses - p0, 0);
    else begin
      chk(req, pulses - p0 == 1, pulses - p0, 1);
      chk(req, rise_cyc - t0 == exp_lat, rise_cyc - t0, exp_lat);
      chk({req, " R4 width"}, width == P, width, P);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, t0;
    repeat (3) @(negedge clk);
    chk("R9 reset pull", pull == 1'b0, pull, 0);
    chk("R8 reset level", rst_lvl == 1'b1, rst_lvl, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3 threshold sweep, normal mode
    run_press(1, -1, "R2 len=1");
    run_press(H - 2, -1, "R2 len=H-2");
    run_press(H - 1, -1, "R2 len=H-1");
    run_press(H, H + 2, "R3 len=H");
    run_press(H + 1, H + 2, "R3 R4 len=H+1");
    run_press(H + P / 2, H + 2, "R4 release mid-pulse");
    run_press(3 * H, H + 2, "R5 held long, one pulse");
    run_press(H, H + 2, "R5 re-armed");

    // R6 / R1 test mode
    sel = 1'b1; repeat (5) @(negedge clk);
    run_press(1, 3, "R6 R1 test short");
    run_press(2 * H, 3, "R6 test held");
    sel = 1'b0; repeat (5) @(negedge clk);
    run_press(H - 1, -1, "R6 back to normal");

    // R7: toggle select while held
    p0 = pulses;
    @(negedge clk); btn_n = 1'b0; t0 = cyc;
    repeat (5) @(negedge clk); sel = 1'b1;
    repeat (3 * H - 10) @(negedge clk); sel = 1'b0;
    repeat (5) @(negedge clk); btn_n = 1'b1;
    repeat (P + 8) @(negedge clk);
    chk("R7 held pulse latency", rise_cyc - t0 == H + 2, rise_cyc - t0, H + 2);
    chk("R7 held pulse count", pulses - p0 == 1, pulses - p0, 1);
    run_press(H - 1, -1, "R7 select change while held ignored");

    // R9 reset mid-pulse
    @(negedge clk); btn_n = 1'b0;
    repeat (H + 4) @(negedge clk);
    chk("R9 pulse active", pull == 1'b1, pull, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 async release", pull == 1'b0, pull, 0);
    chk("R9 level high", rst_lvl == 1'b1, rst_lvl, 1);
    btn_n = 1'b1;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_press(H, H + 2, "R9 normal after reset");

    chk("R8 open-drain level", od_bad == 0, od_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule